// File: doc/BRIEF.md
# Fractional MAC Step with Modulo Operand Prefetch

This block carries out one step of a multiply-accumulate loop. It holds a multiplicand and a multiplier as signed 16-bit fractions. On a start request it forms their doubled product and hands it to an external accumulator in a single-cycle pulse, together with a flag that selects zero extension for the one product that cannot be represented. It then moves two operand pointers through circular buffers and reads the operands for the next step from a 16-bit memory. When the step ends, the holding registers contain fresh data, ready for the next start.

Each pointer is 20 bits wide. It advances by a signed 4-bit step taken from a control byte. A 16-bit mask limits the update to a window of low-order bits, which creates the circular buffer, while the bits outside the mask keep their values. Before it is overwritten, the multiplicand is copied to a third index output. A read from an even address is a single word access. A read from an odd address becomes two byte accesses. A software-visible load port sets the holding registers and the pointers between steps.

Top module: `mac_fetch_seq`

## Requirements
- R1: In the accumulate pulse, `acc_data_o` equals the signed product of the multiplicand and multiplier holding registers multiplied by two, kept to 32 bits.
- R2: `ovf_o` and `acc_zext_o` are 1 exactly when that doubled product equals 0x80000000, which happens only for 0x8000 times 0x8000. Otherwise they are 0.
- R3: Pointer A advances by control-byte bits 7:4, sign-extended from 4 bits.
- R4: Pointer B advances by control-byte bits 3:0, sign-extended from 4 bits.
- R5: A pointer step writes only the low bits set in that pointer's mask. A mask of 0 stands for 0xFFFF. Pointer bits 19:16 never change during a step.
- R6: During the step, `ptr_c_o` receives the multiplicand value that was held before the step.
- R7: The new multiplicand is read at the stepped pointer A, and the new multiplier at the stepped pointer B. At an even address this is one word read (`rd_byte_o`=0), and the returned 16 bits are used as is.
- R8: At an odd address the sequencer makes two byte reads (`rd_byte_o`=1, data in `rd_data_i[7:0]`), first at the address and then at the address plus one, wrapping in 20 bits. The first byte becomes the high half.
- R9: The order is fixed: product, then the accumulate pulse together with the pointer A step, then the read(s) at pointer A, then the pointer B step and the read(s) at pointer B. Read data is due on `rd_data_i` in the cycle after `rd_req_o`.
- R10: `busy_o` rises the cycle after an accepted start and stays high for 5 cycles, plus one cycle for each odd operand address. `start_i` and `ld_i` have no effect while busy.
- R11: While idle, `ld_i` loads both holding registers and both pointers and takes priority over `start_i`. Without `ld_i`, the holding registers stay unchanged in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one MAC step |
| postbyte_i | input | 8 | Pointer steps: [7:4] for A, [3:0] for B |
| mask_a_i | input | 16 | Modulo mask for pointer A |
| mask_b_i | input | 16 | Modulo mask for pointer B |
| ld_i | input | 1 | Load registers while idle |
| ld_hold_a_i | input | 16 | Multiplicand load value |
| ld_hold_b_i | input | 16 | Multiplier load value |
| ld_ptr_a_i | input | 20 | Pointer A load value |
| ld_ptr_b_i | input | 20 | Pointer B load value |
| busy_o | output | 1 | Step in progress |
| ovf_o | output | 1 | Product overflow flag |
| acc_valid_o | output | 1 | Accumulate pulse |
| acc_data_o | output | 32 | Doubled product |
| acc_zext_o | output | 1 | Zero-extend the product when accumulating |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 20 | Read address |
| rd_byte_o | output | 1 | 1 for a byte read, 0 for a word read |
| rd_data_i | input | 16 | Read data, one cycle after the request |
| hold_a_o | output | 16 | Multiplicand holding register |
| hold_b_o | output | 16 | Multiplier holding register |
| ptr_a_o | output | 20 | Pointer A |
| ptr_b_o | output | 20 | Pointer B |
| ptr_c_o | output | 16 | Copy of the previous multiplicand |

## Verification
After the falling edge at which start is raised, the accumulate pulse comes two cycles later, and the first read follows one cycle after the pulse. The holding registers and pointers are final when `busy_o` falls, which happens 5, 6 or 7 cycles after start depending on how many operand addresses are odd. A monitor samples on falling edges and records the cycle of the pulse and every read. The bench compares the logged busy length, the pulse payload, the order of events and the read address list against values it computes itself. It checks the final registers only after busy has dropped.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;
    parameter int MAC_DW   = 16;
    parameter int MAC_AW   = 20;
    parameter int MAC_OFFW = 4;
    localparam int MAC_PW  = 2 * MAC_DW;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_ACC,
        ST_RDA,
        ST_RDA2,
        ST_WRA,
        ST_RDB2,
        ST_WRB
    } seq_st_e;

    typedef struct packed {
        seq_st_e                 st;
        logic [MAC_DW-1:0]       hold_a;
        logic [MAC_DW-1:0]       hold_b;
        logic [MAC_AW-1:0]       ptr_a;
        logic [MAC_AW-1:0]       ptr_b;
        logic [MAC_DW-1:0]       ptr_c;
        logic [MAC_PW-1:0]       prod;
        logic                    ovf;
        logic [2*MAC_OFFW-1:0]   steps;
        logic [MAC_DW-1:0]       mask_a;
        logic [MAC_DW-1:0]       mask_b;
        logic [7:0]              hi_byte;
    } seq_regs_t;
endpackage

// File: rtl/mac_fracmul.sv
module mac_fracmul #(
    parameter int DW = 16,
    localparam int PW = 2 * DW
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [PW-1:0] prod_o,
    output logic          ovf_o
);
    logic signed [DW-1:0] a_s;
    logic signed [DW-1:0] b_s;
    logic signed [PW-1:0] full;
    logic [PW-1:0]        dbl;

    always_comb begin
        a_s    = a_i;
        b_s    = b_i;
        full   = a_s * b_s;
        dbl    = {full[PW-2:0], 1'b0};
        prod_o = dbl;
        ovf_o  = (dbl == {1'b1, {(PW-1){1'b0}}});
    end
endmodule

// File: rtl/mac_ptr_step.sv
module mac_ptr_step #(
    parameter int AW   = 20,
    parameter int DW   = 16,
    parameter int OFFW = 4
) (
    input  logic [AW-1:0]   ptr_i,
    input  logic [DW-1:0]   mask_i,
    input  logic [OFFW-1:0] off_i,
    output logic [AW-1:0]   ptr_o
);
    logic [DW-1:0] eff_mask;
    logic [AW-1:0] wide_mask;
    logic [AW-1:0] off_ext;
    logic [AW-1:0] sum;

    always_comb begin
        eff_mask  = (mask_i == '0) ? {DW{1'b1}} : mask_i;
        wide_mask = {{(AW-DW){1'b0}}, eff_mask};
        off_ext   = {{(AW-OFFW){off_i[OFFW-1]}}, off_i};
        sum       = ptr_i + off_ext;
        ptr_o     = (ptr_i & ~wide_mask) | (sum & wide_mask);
    end
endmodule

// File: rtl/mac_fetch_seq.sv
module mac_fetch_seq
    import mac_seq_pkg::*;
#(
    localparam int DW   = MAC_DW,
    localparam int AW   = MAC_AW,
    localparam int OFFW = MAC_OFFW,
    localparam int PW   = MAC_PW,
    localparam int SW   = 2 * MAC_OFFW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [SW-1:0] postbyte_i,
    input  logic [DW-1:0] mask_a_i,
    input  logic [DW-1:0] mask_b_i,
    input  logic          ld_i,
    input  logic [DW-1:0] ld_hold_a_i,
    input  logic [DW-1:0] ld_hold_b_i,
    input  logic [AW-1:0] ld_ptr_a_i,
    input  logic [AW-1:0] ld_ptr_b_i,
    output logic          busy_o,
    output logic          ovf_o,
    output logic          acc_valid_o,
    output logic [PW-1:0] acc_data_o,
    output logic          acc_zext_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          rd_byte_o,
    input  logic [DW-1:0] rd_data_i,
    output logic [DW-1:0] hold_a_o,
    output logic [DW-1:0] hold_b_o,
    output logic [AW-1:0] ptr_a_o,
    output logic [AW-1:0] ptr_b_o,
    output logic [DW-1:0] ptr_c_o
);
    localparam int NPTR = 2;

    seq_regs_t q, d;

    logic [PW-1:0]   mul_prod;
    logic            mul_ovf;
    logic [AW-1:0]   step_cur  [NPTR];
    logic [DW-1:0]   step_mask [NPTR];
    logic [OFFW-1:0] step_off  [NPTR];
    logic [AW-1:0]   step_nxt  [NPTR];

    mac_fracmul #(.DW(DW)) u_mul (
        .a_i    (q.hold_a),
        .b_i    (q.hold_b),
        .prod_o (mul_prod),
        .ovf_o  (mul_ovf)
    );

    assign step_cur[0]  = q.ptr_a;
    assign step_cur[1]  = q.ptr_b;
    assign step_mask[0] = q.mask_a;
    assign step_mask[1] = q.mask_b;
    assign step_off[0]  = q.steps[SW-1:OFFW];
    assign step_off[1]  = q.steps[OFFW-1:0];

    for (genvar g = 0; g < NPTR; g++) begin : g_step
        mac_ptr_step #(.AW(AW), .DW(DW), .OFFW(OFFW)) u_step (
            .ptr_i  (step_cur[g]),
            .mask_i (step_mask[g]),
            .off_i  (step_off[g]),
            .ptr_o  (step_nxt[g])
        );
    end

    always_comb begin
        d           = q;
        acc_valid_o = 1'b0;
        rd_req_o    = 1'b0;
        rd_addr_o   = '0;
        rd_byte_o   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ld_i) begin
                    d.hold_a = ld_hold_a_i;
                    d.hold_b = ld_hold_b_i;
                    d.ptr_a  = ld_ptr_a_i;
                    d.ptr_b  = ld_ptr_b_i;
                end else if (start_i) begin
                    d.steps  = postbyte_i;
                    d.mask_a = mask_a_i;
                    d.mask_b = mask_b_i;
                    d.st     = ST_MUL;
                end
            end
            ST_MUL: begin
                d.prod = mul_prod;
                d.ovf  = mul_ovf;
                d.st   = ST_ACC;
            end
            ST_ACC: begin
                acc_valid_o = 1'b1;
                d.ptr_a     = step_nxt[0];
                d.st        = ST_RDA;
            end
            ST_RDA: begin
                d.ptr_c   = q.hold_a;
                rd_req_o  = 1'b1;
                rd_addr_o = q.ptr_a;
                rd_byte_o = q.ptr_a[0];
                d.st      = q.ptr_a[0] ? ST_RDA2 : ST_WRA;
            end
            ST_RDA2: begin
                d.hi_byte = rd_data_i[7:0];
                rd_req_o  = 1'b1;
                rd_addr_o = q.ptr_a + AW'(1);
                rd_byte_o = 1'b1;
                d.st      = ST_WRA;
            end
            ST_WRA: begin
                d.hold_a  = q.ptr_a[0] ? {q.hi_byte, rd_data_i[7:0]} : rd_data_i;
                d.ptr_b   = step_nxt[1];
                rd_req_o  = 1'b1;
                rd_addr_o = step_nxt[1];
                rd_byte_o = step_nxt[1][0];
                d.st      = step_nxt[1][0] ? ST_RDB2 : ST_WRB;
            end
            ST_RDB2: begin
                d.hi_byte = rd_data_i[7:0];
                rd_req_o  = 1'b1;
                rd_addr_o = q.ptr_b + AW'(1);
                rd_byte_o = 1'b1;
                d.st      = ST_WRB;
            end
            ST_WRB: begin
                d.hold_b = q.ptr_b[0] ? {q.hi_byte, rd_data_i[7:0]} : rd_data_i;
                d.st     = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != ST_IDLE);
    assign ovf_o      = q.ovf;
    assign acc_data_o = q.prod;
    assign acc_zext_o = q.ovf;
    assign hold_a_o   = q.hold_a;
    assign hold_b_o   = q.hold_b;
    assign ptr_a_o    = q.ptr_a;
    assign ptr_b_o    = q.ptr_b;
    assign ptr_c_o    = q.ptr_c;
endmodule

// File: rtl/mac_fetch_seq_chk.sv
module mac_fetch_seq_chk #(
    parameter int DW = 16,
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          ld_i,
    input logic          busy_o,
    input logic          acc_valid_o,
    input logic [2*DW-1:0] acc_data_o,
    input logic          acc_zext_o,
    input logic          rd_req_o,
    input logic [DW-1:0] hold_a_o,
    input logic [DW-1:0] hold_b_o,
    input logic [AW-1:0] ptr_a_o,
    input logic [AW-1:0] ptr_b_o
);
    // R2
    zext_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o |-> (acc_zext_o == (acc_data_o == {1'b1, {(2*DW-1){1'b0}}})));

    // R9
    acc_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o |=> (rd_req_o && !acc_valid_o));

    // R9
    read_in_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> busy_o);

    // R10
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !ld_i) |=> busy_o);

    // R5
    ptr_a_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_i && !busy_o) |=> $stable(ptr_a_o[AW-1:DW]));

    // R5
    ptr_b_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_i && !busy_o) |=> $stable(ptr_b_o[AW-1:DW]));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !ld_i) |=> ($stable(hold_a_o) && $stable(hold_b_o)));
endmodule

bind mac_fetch_seq mac_fetch_seq_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ld_i        (ld_i),
    .busy_o      (busy_o),
    .acc_valid_o (acc_valid_o),
    .acc_data_o  (acc_data_o),
    .acc_zext_o  (acc_zext_o),
    .rd_req_o    (rd_req_o),
    .hold_a_o    (hold_a_o),
    .hold_b_o    (hold_b_o),
    .ptr_a_o     (ptr_a_o),
    .ptr_b_o     (ptr_b_o)
);

// File: tb/mac_fetch_seq_bench.sv
module mac_fetch_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  postbyte_i = '0;
    logic [15:0] mask_a_i = '0, mask_b_i = '0;
    logic        ld_i = 1'b0;
    logic [15:0] ld_hold_a_i = '0, ld_hold_b_i = '0;
    logic [19:0] ld_ptr_a_i = '0, ld_ptr_b_i = '0;
    logic        busy_o, ovf_o, acc_valid_o, acc_zext_o, rd_req_o, rd_byte_o;
    logic [31:0] acc_data_o;
    logic [19:0] rd_addr_o, ptr_a_o, ptr_b_o;
    logic [15:0] rd_data_i = '0, hold_a_o, hold_b_o, ptr_c_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mac_fetch_seq u_mac_fetch_seq (.*);

    function automatic logic [7:0] mbyte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h5};
    endfunction

    function automatic logic [15:0] mword(input logic [19:0] a);
        return {mbyte(a), mbyte(a + 20'd1)};
    endfunction

    always_ff @(posedge clk)
        if (rd_req_o)
            rd_data_i <= rd_byte_o ? {8'h00, mbyte(rd_addr_o)} : mword(rd_addr_o);

    function automatic logic [19:0] mstep(input logic [19:0] p, input logic [15:0] m,
                                          input logic [3:0] off);
        logic [15:0] eff = (m == 16'h0) ? 16'hFFFF : m;
        logic [19:0] s = p + {{16{off[3]}}, off};
        logic [19:0] r = p;
        for (int i = 0; i < 16; i++) if (eff[i]) r[i] = s[i];
        return r;
    endfunction

    // monitor
    int cyc, acc_seen, acc_cyc, rd_n, rd_cyc0;
    logic [31:0] acc_val;
    logic        acc_z;
    logic [19:0] rd_a [4];
    logic        rd_b [4];

    always @(negedge clk) begin
        if (busy_o) cyc++;
        if (acc_valid_o) begin
            acc_seen++; acc_val = acc_data_o; acc_z = acc_zext_o; acc_cyc = cyc;
        end
        if (rd_req_o) begin
            if (rd_n == 0) rd_cyc0 = cyc;
            if (rd_n < 4) begin rd_a[rd_n] = rd_addr_o; rd_b[rd_n] = rd_byte_o; end
            rd_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [15:0] m_ha, m_hb, m_pc;
    logic [19:0] m_pa, m_pb;

    task automatic load(input logic [15:0] ha, hb, input logic [19:0] pa, pb);
        @(negedge clk);
        ld_i = 1; ld_hold_a_i = ha; ld_hold_b_i = hb; ld_ptr_a_i = pa; ld_ptr_b_i = pb;
        @(negedge clk);
        ld_i = 0;
        m_ha = ha; m_hb = hb; m_pa = pa; m_pb = pb;
        chk("R11 load hold_a", 32'(hold_a_o), 32'(ha));
        chk("R11 load hold_b", 32'(hold_b_o), 32'(hb));
        chk("R11 load ptr_a", 32'(ptr_a_o), 32'(pa));
        chk("R11 load ptr_b", 32'(ptr_b_o), 32'(pb));
    endtask

    task automatic run_op(input logic [7:0] pb, input logic [15:0] ma, mb, input bit poke);
        logic signed [31:0] full;
        logic [31:0] prod;
        logic        ovf;
        logic [19:0] na, nb;
        logic [19:0] ea [4];
        logic        eb [4];
        int          ne, wait_n;
        full = $signed(m_ha) * $signed(m_hb);
        prod = {full[30:0], 1'b0};
        ovf  = (prod == 32'h8000_0000);
        na = mstep(m_pa, ma, pb[7:4]);
        nb = mstep(m_pb, mb, pb[3:0]);
        ne = 0;
        ea[ne] = na; eb[ne] = na[0]; ne++;
        if (na[0]) begin ea[ne] = na + 20'd1; eb[ne] = 1; ne++; end
        ea[ne] = nb; eb[ne] = nb[0]; ne++;
        if (nb[0]) begin ea[ne] = nb + 20'd1; eb[ne] = 1; ne++; end

        @(negedge clk);
        cyc = 0; acc_seen = 0; rd_n = 0; acc_cyc = -1; rd_cyc0 = -1;
        start_i = 1; postbyte_i = pb; mask_a_i = ma; mask_b_i = mb;
        @(negedge clk);
        if (poke) begin
            // R10: a second start and a load while busy must change nothing
            postbyte_i = ~pb; mask_a_i = 16'h0001; ld_i = 1;
            ld_hold_a_i = 16'hDEAD; ld_ptr_a_i = 20'h12345; ld_ptr_b_i = 20'h54321;
            @(negedge clk); @(negedge clk);
            ld_i = 0;
        end
        start_i = 0;
        wait_n = 0;
        while (busy_o && wait_n < 50) begin @(negedge clk); wait_n++; end

        chk("R10 busy length", 32'(cyc), 32'(5 + int'(na[0]) + int'(nb[0])));
        chk("R10 idle after step", 32'(busy_o), 32'd0);
        chk("R1 acc pulse count", 32'(acc_seen), 32'd1);
        chk("R1 product", acc_val, prod);
        chk("R2 zext flag", 32'(acc_z), 32'(ovf));
        chk("R2 ovf_o", 32'(ovf_o), 32'(ovf));
        chk("R9 acc cycle", 32'(acc_cyc), 32'd2);
        chk("R9 first read after acc", 32'(rd_cyc0), 32'd3);
        chk("R3 ptr_a", 32'(ptr_a_o), 32'(na));
        chk("R4 ptr_b", 32'(ptr_b_o), 32'(nb));
        chk("R5 ptr_a upper", 32'(ptr_a_o[19:16]), 32'(m_pa[19:16]));
        chk("R6 ptr_c", 32'(ptr_c_o), 32'(m_ha));
        chk("R8 read count", 32'(rd_n), 32'(ne));
        for (int i = 0; i < ne && i < rd_n && i < 4; i++) begin
            chk(eb[i] ? "R8 byte read addr" : "R7 word read addr", 32'(rd_a[i]), 32'(ea[i]));
            chk(eb[i] ? "R8 byte read kind" : "R7 word read kind", 32'(rd_b[i]), 32'(eb[i]));
        end
        chk(na[0] ? "R8 hold_a split" : "R7 hold_a word", 32'(hold_a_o), 32'(mword(na)));
        chk(nb[0] ? "R8 hold_b split" : "R7 hold_b word", 32'(hold_b_o), 32'(mword(nb)));
        m_pc = m_ha; m_ha = mword(na); m_hb = mword(nb); m_pa = na; m_pb = nb;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=complete");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        chk("R10 reset busy", 32'(busy_o), 32'd0);
        chk("R11 reset hold_a", 32'(hold_a_o), 32'd0);
        chk("R2 reset ovf", 32'(ovf_o), 32'd0);
        rst_n = 1;
        @(negedge clk);

        load(16'h4000, 16'h2000, 20'h10000, 20'h20010);   // even A, odd B
        run_op(8'h21, 16'h0000, 16'h0000, 0);
        load(16'h8000, 16'h8000, 20'h00101, 20'h00203);   // overflow product
        run_op(8'hF3, 16'h0000, 16'h0000, 0);
        load(16'h7FFF, 16'h8001, 20'h3000E, 20'h4FFF1);   // modulo windows
        run_op(8'h4D, 16'h000F, 16'h00FF, 1);
        load(16'hFFFF, 16'h0001, 20'hFFFFE, 20'hFFFFF);   // odd at top, wrap
        run_op(8'h11, 16'h0000, 16'h0000, 0);
        load(16'h1234, 16'hFEDC, 20'h5FFFF, 20'h6FFFF);   // full-mask wrap keeps upper
        run_op(8'h11, 16'hFFFF, 16'h0000, 1);
        for (int k = 0; k < 60; k++) begin
            if (k % 10 == 0)
                load(16'($urandom), 16'($urandom), 20'($urandom), 20'($urandom));
            run_op(8'($urandom), (k % 3 == 0) ? 16'h0000 : 16'($urandom),
                   (k % 4 == 0) ? 16'h0000 : 16'($urandom), (k % 7 == 0));
        end
        finish_up();
    end
endmodule